// File: doc/BRIEF.md
# Double-Buffered Asynchronous Serial Transmitter

This block turns bytes that software writes into asynchronous serial frames on one output line. A frame is a low start bit, the data bits least significant first, an optional ninth bit, and one high stop bit. Each bit lasts a fixed number of strobes on a baud-enable input. Between frames the line idles high. An external divider produces the baud strobe.

A mode input selects one of two buffering schemes. With buffering off, the transmitter acts as a classic single-buffer UART. A write to an idle shifter starts a frame at once. The ninth bit is taken live from its control input while that bit is on the line. The interrupt flag marks the end of the frame. With buffering on, every write lands in a holding register, and the ninth bit is captured at the same moment. The holding register passes its character to the shifter as soon as the shifter is idle or is just finishing a stop bit, so a character written during a frame follows it with no gap. In this mode the interrupt flag marks the moment the holding register becomes free again.

A write that finds no room is dropped and sets an overrun flag. Both flags are sticky and are cleared by one clear strobe. A set event in the same cycle as the clear wins.

Top module: `dbuf_uart_tx`

## Requirements
- R1: After reset the line is high, both flags are low and the buffer-ready output is high.
- R2: A frame puts on the line a 0 start bit, then the data bits LSB first, then a 1 stop bit. The line is 1 whenever no frame is running.
- R3: When `frame9_i` is 1, one extra data bit is sent between the last data bit and the stop bit. When it is 0, there is no extra bit.
- R4: Each bit lasts exactly 16 cycles in which `baud_tick_i` is 1. Cycles without a strobe do not advance the frame.
- R5: With `dbuf_en_i` at 0, a write to an idle transmitter drives the start bit from the next clock edge. `irq_o` sets at the edge that ends the stop bit. `hold_ready_o` is 1 only while idle.
- R6: With `dbuf_en_i` at 1, a write enters the holding register. If the shifter is idle, the character moves to the shifter at the following edge, the start bit begins there, and `irq_o` sets at that same edge.
- R7: With `dbuf_en_i` at 0, the ninth bit on the line follows `bit9_i` during that bit period. A change made after the data write but before that bit still takes effect.
- R8: With `dbuf_en_i` at 1, the ninth bit is the value of `bit9_i` at the data write. Later changes of `bit9_i` do not affect that character.
- R9: With `dbuf_en_i` at 1, a character held when a stop bit ends starts its start bit at that very edge, so there is exactly one stop bit between the two frames.
- R10: With `dbuf_en_i` at 1, `hold_ready_o` is 0 while the holding register is occupied and 1 once it has passed its character on.
- R11: A write that finds no room is ignored and sets `overrun_o`. No room means a busy shifter in single mode, or an occupied holding register not being emptied that cycle in buffered mode.
- R12: `irq_o` and `overrun_o` stay set until `flag_clr_i` is 1. A set event in the same cycle as the clear leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| baud_tick_i | input | 1 | Baud enable strobe, 16 per bit |
| dbuf_en_i | input | 1 | 1 selects double buffering |
| frame9_i | input | 1 | 1 selects the 9-data-bit frame |
| bit9_i | input | 1 | Ninth data bit control value |
| wr_i | input | 1 | Data write strobe |
| wr_data_i | input | DATA_W | Data byte to send |
| flag_clr_i | input | 1 | Clears irq_o and overrun_o |
| txd_o | output | 1 | Serial line |
| irq_o | output | 1 | Transmit interrupt flag |
| hold_ready_o | output | 1 | Transmitter can accept a write |
| overrun_o | output | 1 | A write was dropped |

## Verification
The assertions check every cycle that the line holds still between bit boundaries and that the tick counter stands when no strobe comes. They also check that a held character starts at the edge that ends a stop bit, that a single-mode write to an idle shifter pulls the line low one edge later, that a dropped write raises overrun and clears ready, that a held character stays unchanged, and that a set always beats a clear. Only the bench scenarios can show the full bit order of each frame type. They also show where the ninth bit comes from in each mode, the exact cycle of the interrupt in each mode, the gapless chaining of two frames, and that an overrun write never reaches the line.

// File: rtl/dbuf_uart_pkg.sv
package dbuf_uart_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_BIT9,
    ST_STOP
  } tx_state_e;
endpackage

// File: rtl/tx_bit_timer.sv
module tx_bit_timer #(
  parameter int TICKS_PER_BIT = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic tick_i,
  output logic bit_done_o
);
  localparam int TICK_W = (TICKS_PER_BIT > 1) ? $clog2(TICKS_PER_BIT) : 1;
  localparam logic [TICK_W-1:0] LAST_TICK = TICK_W'(TICKS_PER_BIT - 1);

  logic [TICK_W-1:0] cnt_q;

  assign bit_done_o = run_i && tick_i && (cnt_q == LAST_TICK);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (!run_i)          cnt_q <= '0;
    else if (tick_i)          cnt_q <= (cnt_q == LAST_TICK) ? '0 : cnt_q + 1'b1;
  end

  // count only advances on a strobe
  assert_tick_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !tick_i) |=> $stable(cnt_q));
endmodule

// File: rtl/tx_hold_buf.sv
module tx_hold_buf #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              wr_b9_i,
  input  logic              take_i,
  output logic              full_o,
  output logic [DATA_W-1:0] data_o,
  output logic              b9_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_o <= 1'b0;
      data_o <= '0;
      b9_o   <= 1'b0;
    end else begin
      if (wr_i) begin
        full_o <= 1'b1;
        data_o <= wr_data_i;
        b9_o   <= wr_b9_i;
      end else if (take_i) begin
        full_o <= 1'b0;
      end
    end
  end

  // held character and its ninth bit are frozen until a new write
  assert_hold_stable_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && !wr_i) |=> ($stable(data_o) && $stable(b9_o)));
endmodule

// File: rtl/tx_flag.sv
module tx_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_o <= 1'b0;
    else if (set_i)  q_o <= 1'b1;
    else if (clr_i)  q_o <= 1'b0;
  end

  assert_set_wins_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> q_o);
  assert_clear_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!set_i && clr_i) |=> !q_o);
endmodule

// File: rtl/tx_shift_fsm.sv
module tx_shift_fsm
  import dbuf_uart_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bit_done_i,
  input  logic              frame9_i,
  input  logic              live_b9_sel_i,
  input  logic              live_b9_i,
  input  logic              load_i,
  input  logic [DATA_W-1:0] load_data_i,
  input  logic              load_b9_i,
  output logic              busy_o,
  output logic              frame_end_o,
  output logic              txd_o
);
  localparam int BIT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(DATA_W - 1);

  tx_state_e         state_q;
  logic [DATA_W-1:0] shreg_q;
  logic [BIT_W-1:0]  bit_cnt_q;
  logic              b9_q;
  logic              start_new;

  assign busy_o      = (state_q != ST_IDLE);
  assign frame_end_o = (state_q == ST_STOP) && bit_done_i;
  assign start_new   = load_i && ((state_q == ST_IDLE) || frame_end_o);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      shreg_q   <= '0;
      bit_cnt_q <= '0;
      b9_q      <= 1'b0;
    end else if (start_new) begin
      state_q   <= ST_START;
      shreg_q   <= load_data_i;
      bit_cnt_q <= '0;
      b9_q      <= load_b9_i;
    end else if (bit_done_i) begin
      unique case (state_q)
        ST_START: state_q <= ST_DATA;
        ST_DATA: begin
          shreg_q <= shreg_q >> 1;
          if (bit_cnt_q == LAST_BIT) state_q <= frame9_i ? ST_BIT9 : ST_STOP;
          else                       bit_cnt_q <= bit_cnt_q + 1'b1;
        end
        ST_BIT9: state_q <= ST_STOP;
        ST_STOP: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    unique case (state_q)
      ST_START: txd_o = 1'b0;
      ST_DATA:  txd_o = shreg_q[0];
      ST_BIT9:  txd_o = live_b9_sel_i ? live_b9_i : b9_q;
      default:  txd_o = 1'b1;
    endcase
  end

  // line only moves at bit boundaries (live ninth bit excepted)
  assert_line_steady_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !bit_done_i && !(state_q == ST_BIT9 && live_b9_sel_i)) |=> $stable(txd_o));
endmodule

// File: rtl/dbuf_uart_tx.sv
module dbuf_uart_tx #(
  parameter int DATA_W        = 8,
  parameter int TICKS_PER_BIT = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              baud_tick_i,
  input  logic              dbuf_en_i,
  input  logic              frame9_i,
  input  logic              bit9_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              flag_clr_i,
  output logic              txd_o,
  output logic              irq_o,
  output logic              hold_ready_o,
  output logic              overrun_o
);
  logic              busy, idle, bit_done, frame_end;
  logic              hold_full, hold_b9, hold_wr, take;
  logic [DATA_W-1:0] hold_data;
  logic              sh_load, sh_b9, irq_set, ovr_set;
  logic [DATA_W-1:0] sh_data;

  assign idle    = !busy;
  // holding register empties when shifter is idle or ends a stop bit
  assign take    = dbuf_en_i && hold_full && (idle || frame_end);
  assign hold_wr = dbuf_en_i && wr_i && (!hold_full || take);

  assign sh_load = dbuf_en_i ? take      : (wr_i && idle);
  assign sh_data = dbuf_en_i ? hold_data : wr_data_i;
  assign sh_b9   = dbuf_en_i ? hold_b9   : bit9_i;

  assign irq_set = dbuf_en_i ? take : frame_end;
  assign ovr_set = wr_i && (dbuf_en_i ? !hold_wr : !idle);

  assign hold_ready_o = dbuf_en_i ? !hold_full : idle;

  tx_bit_timer #(.TICKS_PER_BIT(TICKS_PER_BIT)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .run_i      (busy),
    .tick_i     (baud_tick_i),
    .bit_done_o (bit_done)
  );

  tx_hold_buf #(.DATA_W(DATA_W)) u_hold (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (hold_wr),
    .wr_data_i (wr_data_i),
    .wr_b9_i   (bit9_i),
    .take_i    (take),
    .full_o    (hold_full),
    .data_o    (hold_data),
    .b9_o      (hold_b9)
  );

  tx_shift_fsm #(.DATA_W(DATA_W)) u_fsm (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .bit_done_i    (bit_done),
    .frame9_i      (frame9_i),
    .live_b9_sel_i (!dbuf_en_i),
    .live_b9_i     (bit9_i),
    .load_i        (sh_load),
    .load_data_i   (sh_data),
    .load_b9_i     (sh_b9),
    .busy_o        (busy),
    .frame_end_o   (frame_end),
    .txd_o         (txd_o)
  );

  tx_flag u_irq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (irq_set),
    .clr_i  (flag_clr_i),
    .q_o    (irq_o)
  );

  tx_flag u_ovr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (ovr_set),
    .clr_i  (flag_clr_i),
    .q_o    (overrun_o)
  );

  assert_chain_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dbuf_en_i && hold_full && frame_end) |=> !txd_o);
  assert_single_start_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dbuf_en_i && wr_i && idle) |=> !txd_o);
  assert_overrun_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dbuf_en_i && wr_i && hold_full && !take) |=> overrun_o);
  assert_ready_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_wr |=> (!dbuf_en_i || !hold_ready_o));
endmodule

// File: tb/dbuf_uart_tx_tb.sv
module dbuf_uart_tx_tb;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       baud_tick = 1'b1;
  logic       half_rate = 1'b0;
  logic       dbuf_en = 1'b0, frame9 = 1'b0, bit9 = 1'b0;
  logic       wr = 1'b0, flag_clr = 1'b0;
  logic [7:0] wr_data = '0;
  logic       txd, irq, hold_ready, overrun;
  int         n_chk = 0, n_err = 0;
  bit         done = 1'b0;

  always #2 clk = ~clk;
  always @(negedge clk) baud_tick <= half_rate ? ~baud_tick : 1'b1;

  dbuf_uart_tx u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .baud_tick_i(baud_tick), .dbuf_en_i(dbuf_en),
    .frame9_i(frame9), .bit9_i(bit9), .wr_i(wr), .wr_data_i(wr_data),
    .flag_clr_i(flag_clr), .txd_o(txd), .irq_o(irq), .hold_ready_o(hold_ready),
    .overrun_o(overrun)
  );

  typedef struct packed { logic dbuf; logic f9; logic b9; logic [7:0] d; } vec_t;
  localparam vec_t VECS [6] = '{
    '{1'b0, 1'b0, 1'b0, 8'hA5}, '{1'b0, 1'b1, 1'b1, 8'h3C}, '{1'b0, 1'b1, 1'b0, 8'hFF},
    '{1'b1, 1'b0, 1'b0, 8'h5A}, '{1'b1, 1'b1, 1'b1, 8'h00}, '{1'b1, 1'b1, 1'b0, 8'h81}};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wr_byte(input logic [7:0] d);
    wr = 1'b1; wr_data = d;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic clr_flags();
    flag_clr = 1'b1;
    @(negedge clk);
    flag_clr = 1'b0;
  endtask

  // starts at the negedge after the write edge; off = cycles to the start bit
  // irq_mode 0: none, 1: single-buffer timing, 2: double-buffer timing
  task automatic frame_check(input int off, input logic [7:0] d, input logic b9,
                             input logic f9, input int irq_mode, input string tag9);
    int nb;
    nb = f9 ? 11 : 10;
    for (int m = 0; m <= off + 16 * nb; m++) begin
      if (m > 0) @(negedge clk);
      if (m >= off + 8 && ((m - off - 8) % 16) == 0) begin
        int k;
        k = (m - off - 8) / 16;
        if (k == 0)                 chk("R2 start", txd, 0);
        else if (k <= 8)            chk("R2 data", txd, d[k-1]);
        else if (f9 && k == 9)      chk(tag9, txd, b9);
        else                        chk("R2 stop", txd, 1);
      end
      if (irq_mode == 1) begin
        if (m == 0)               chk("R5 ready low", hold_ready, 0);
        if (m == off + 16*nb - 1) chk("R5 irq before end", irq, 0);
        if (m == off + 16*nb) begin
          chk("R5 irq at end", irq, 1);
          chk("R5 ready idle", hold_ready, 1);
          chk("R2 idle high", txd, 1);
        end
      end else if (irq_mode == 2) begin
        if (m == 0) begin
          chk("R6 irq before take", irq, 0);
          chk("R10 ready while held", hold_ready, 0);
        end
        if (m == 1) begin
          chk("R6 irq at take", irq, 1);
          chk("R10 ready after take", hold_ready, 1);
        end
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 txd in reset", txd, 1);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 txd", txd, 1);
    chk("R1 irq", irq, 0);
    chk("R1 overrun", overrun, 0);
    chk("R1 ready", hold_ready, 1);

    // table of frame vectors
    for (int i = 0; i < 6; i++) begin
      dbuf_en = VECS[i].dbuf; frame9 = VECS[i].f9; bit9 = VECS[i].b9;
      clr_flags();
      wr_byte(VECS[i].d);
      frame_check(VECS[i].dbuf ? 1 : 0, VECS[i].d, VECS[i].b9, VECS[i].f9,
                  VECS[i].dbuf ? 2 : 1, "R3");
      repeat (4) @(negedge clk);
      chk("R3 idle after frame", txd, 1);
    end

    // R7: live ninth bit in single mode
    dbuf_en = 1'b0; frame9 = 1'b1; bit9 = 1'b0;
    clr_flags();
    wr_byte(8'h00);
    fork
      frame_check(0, 8'h00, 1'b1, 1'b1, 1, "R7 live ninth bit");
      begin repeat (100) @(negedge clk); bit9 = 1'b1; end
    join
    repeat (4) @(negedge clk);

    // R8: ninth bit captured at write in double mode
    dbuf_en = 1'b1; frame9 = 1'b1; bit9 = 1'b1;
    clr_flags();
    wr_byte(8'hC3);
    fork
      frame_check(0, 8'hC3, 1'b1, 1'b1, 0, "R8 captured ninth bit");
      begin @(negedge clk); bit9 = 1'b0; end
    join
    repeat (4) @(negedge clk);

    // R9/R10: back-to-back frames in double mode
    frame9 = 1'b0;
    clr_flags();
    wr_byte(8'h96);
    fork
      frame_check(1, 8'h96, 1'b0, 1'b0, 2, "R3");
      begin
        repeat (80) @(negedge clk);
        clr_flags();
        wr_byte(8'h4B);
        chk("R10 ready low while held", hold_ready, 0);
        chk("R9 irq not yet", irq, 0);
      end
    join
    chk("R9 next start at stop end", txd, 0);
    chk("R9 irq on chain take", irq, 1);
    chk("R10 ready after chain take", hold_ready, 1);
    frame_check(0, 8'h4B, 1'b0, 1'b0, 0, "R3");
    repeat (4) @(negedge clk);

    // R11: overrun in double mode, dropped byte never sent
    clr_flags();
    wr_byte(8'h11);
    wr_byte(8'h22);
    wr_byte(8'h33);
    chk("R11 overrun set", overrun, 1);
    chk("R11 ready low", hold_ready, 0);
    repeat (159) @(negedge clk);
    frame_check(0, 8'h22, 1'b0, 1'b0, 0, "R3");
    repeat (20) @(negedge clk);
    chk("R11 dropped byte not sent", txd, 1);

    // R11: overrun in single mode
    dbuf_en = 1'b0;
    clr_flags();
    chk("R12 overrun cleared", overrun, 0);
    wr_byte(8'h6D);
    fork
      frame_check(0, 8'h6D, 1'b0, 1'b0, 1, "R3");
      begin wr_byte(8'hF0); chk("R11 single overrun", overrun, 1); end
    join
    repeat (20) @(negedge clk);
    chk("R11 single byte dropped", txd, 1);

    // R12: set wins over clear, then clear
    dbuf_en = 1'b1;
    clr_flags();
    chk("R12 irq cleared", irq, 0);
    wr_byte(8'h77);
    flag_clr = 1'b1;
    @(negedge clk);
    flag_clr = 1'b0;
    chk("R12 set wins", irq, 1);
    repeat (5) @(negedge clk);
    chk("R12 irq sticky", irq, 1);
    clr_flags();
    chk("R12 irq clear", irq, 0);
    repeat (170) @(negedge clk);

    // R4: half-rate strobe doubles bit length
    dbuf_en = 1'b0; frame9 = 1'b0;
    half_rate = 1'b1;
    @(negedge clk);
    wr_byte(8'h01);
    repeat (24) @(negedge clk);
    chk("R4 still start bit", txd, 0);
    repeat (24) @(negedge clk);
    chk("R4 data bit0", txd, 1);
    repeat (32) @(negedge clk);
    chk("R4 data bit1", txd, 0);
    repeat (260) @(negedge clk);
    half_rate = 1'b0;
    repeat (4) @(negedge clk);
    chk("R4 frame done", txd, 1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule